// File: doc/BRIEF.md
# Floating-Point Field Unpack and Repack Unit

This unit splits a 64-bit binary64 value into the pieces that a software floating-point routine works on. It also rebuilds an encoded value from those pieces. Both paths are computed every cycle from their own inputs, and every output is registered, so results appear one clock after the inputs are applied.

The unpack path returns four things: the sign, the unbiased exponent, the significand with the hidden bit written out, and the operand class. Software can then branch on zero, subnormal, infinity or NaN without first decoding the exponent field itself.

Two mode inputs change the shape of the unpack results:
- The flag mode replaces the encoded class value with one flag line per class, so a multiway branch can test single bits.
- The split mode returns the significand as two 32-bit halves, which suits code that builds a wide product from 32x32 multiplies.

The repack path takes a sign, an unbiased exponent, a significand and a class code. It produces the encoded word. When fed with unpack results in the default modes, it returns the original operand bit for bit.

Top module: `fp_pack_unit`

## Requirements
- R1: For a normal operand (exponent field from 1 to 2046), unpack gives up_sign equal to bit 63, up_exp equal to the exponent field minus 1023 (12-bit two's complement), up_sig equal to the fraction (bits 51:0) with bit 52 set, and class code 2.
- R2: For a subnormal operand (exponent field 0, fraction nonzero), unpack gives up_sig equal to the fraction with bit 52 clear, up_exp equal to -1022, and class code 1.
- R3: For a zero operand (bits 62:0 all clear), unpack gives class code 0, up_exp 0 and up_sig 0, and keeps the sign bit.
- R4: For an exponent field of all ones, unpack gives up_exp equal to 1024 and up_sig equal to the fraction. The class code is 3 (infinity) when the fraction is zero, 4 (quiet NaN) when fraction bit 51 is set, and 5 (signalling NaN) otherwise.
- R5: With flag_mode low, up_class carries the class code and up_flags is all zero.
- R6: With flag_mode high, up_class is 0 and up_flags has exactly one bit set, at the index equal to the class code.
- R7: With split_mode high, up_sig is 0, up_sig_hi carries bits 63:32 of the significand zero-extended to 64 bits, and up_sig_lo carries bits 31:0. With split_mode low, up_sig carries the significand and both halves are 0.
- R8: For repack class 2, rp_out is {pk_sign, pk_exp+1023 in 11 bits, pk_sig[51:0]}. For repack class 1, the exponent field is 0 and the fraction is pk_sig[51:0].
- R9: For repack class 4 or 5, the exponent field of rp_out is all ones and the fraction is pk_sig[51:0] unchanged.
- R10: For repack class 0, 3, 6 or 7, pk_sig and pk_exp have no effect. Class 3 gives {pk_sign, all-ones exponent, zero fraction}, and classes 0, 6 and 7 give a zero carrying pk_sign.
- R11: All outputs are registered with one cycle of latency. A synchronous active-high reset clears every output to 0.
- R12: In the default modes, repacking the unpack results of any operand gives back the operand bit-exactly, including the sign of zero and NaN payloads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flag_mode | input | 1 | 1: per-class flags, 0: encoded class value |
| split_mode | input | 1 | 1: significand as two halves, 0: single word |
| fp_in | input | 64 | Operand for unpack |
| pk_sign | input | 1 | Repack sign |
| pk_exp | input | 12 | Repack unbiased exponent, two's complement |
| pk_sig | input | 53 | Repack significand, hidden bit at 52 |
| pk_class | input | 3 | Repack class code |
| up_sign | output | 1 | Unpacked sign |
| up_exp | output | 12 | Unpacked unbiased exponent |
| up_sig | output | 53 | Unpacked significand (single-word mode) |
| up_sig_hi | output | 32 | Upper significand half (split mode) |
| up_sig_lo | output | 32 | Lower significand half (split mode) |
| up_class | output | 3 | Class code (code mode) |
| up_flags | output | 6 | One-hot class flags (flag mode) |
| rp_out | output | 64 | Repacked encoded value |

## Verification
Several corner cases are targeted:
- The boundary between subnormal and normal, where a unit that sets the hidden bit or applies the bias wrongly would report -1023 or lose bit 52.
- Quiet and signalling NaNs that differ only in fraction bit 51, which an unpack that tests the wrong bit would swap.
- Negative zero and NaN payloads pushed through unpack and then repack, where a repack that drops the sign or rebuilds a fixed NaN would fail to reproduce the input.
- Repack of zero and infinity with garbage significands, which exposes a unit that leaks the fraction into those encodings.
- The one-hot flag layout and the 32-bit half split, each exercised on several classes.

// File: rtl/fpk_pkg.sv
package fpk_pkg;
  typedef enum logic [2:0] {
    CL_ZERO = 3'd0,
    CL_SUB  = 3'd1,
    CL_NORM = 3'd2,
    CL_INF  = 3'd3,
    CL_QNAN = 3'd4,
    CL_SNAN = 3'd5
  } fp_class_e;

  localparam int N_CLASS = 6;
endpackage

// File: rtl/fp_unpack_core.sv
module fp_unpack_core
  import fpk_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int W     = 1 + EXP_W + FRAC_W,
  localparam int XW    = EXP_W + 1,
  localparam int SIG_W = FRAC_W + 1
) (
  input  logic [W-1:0]     fp_i,
  output logic             sign_o,
  output logic [XW-1:0]    exp_o,
  output logic [SIG_W-1:0] sig_o,
  output fp_class_e        cls_o
);
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;

  logic [EXP_W-1:0]  efield;
  logic [FRAC_W-1:0] frac;
  logic              e_zero, e_ones, f_zero;

  assign efield = fp_i[FRAC_W +: EXP_W];
  assign frac   = fp_i[FRAC_W-1:0];
  assign sign_o = fp_i[W-1];
  assign e_zero = (efield == '0);
  assign e_ones = (efield == '1);
  assign f_zero = (frac == '0);

  always_comb begin
    cls_o = CL_NORM;
    exp_o = XW'(efield) - XW'(BIAS);
    sig_o = {1'b1, frac};
    if (e_zero && f_zero) begin
      cls_o = CL_ZERO;
      exp_o = '0;
      sig_o = '0;
    end else if (e_zero) begin
      cls_o = CL_SUB;
      exp_o = XW'(1) - XW'(BIAS);
      sig_o = {1'b0, frac};
    end else if (e_ones) begin
      exp_o = XW'(BIAS + 1);
      sig_o = {1'b0, frac};
      if (f_zero)               cls_o = CL_INF;
      else if (frac[FRAC_W-1])  cls_o = CL_QNAN;
      else                      cls_o = CL_SNAN;
    end
  end
endmodule

// File: rtl/fp_repack_core.sv
module fp_repack_core
  import fpk_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int W     = 1 + EXP_W + FRAC_W,
  localparam int XW    = EXP_W + 1,
  localparam int SIG_W = FRAC_W + 1
) (
  input  logic             sign_i,
  input  logic [XW-1:0]    exp_i,
  input  logic [SIG_W-1:0] sig_i,
  input  logic [2:0]       cls_i,
  output logic [W-1:0]     fp_o
);
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;

  logic [EXP_W-1:0]  efield;
  logic [FRAC_W-1:0] frac;
  logic              unused_bits;

  // Hidden bit and exponent sign carry no information once the class is known.
  assign unused_bits = ^{sig_i[SIG_W-1], exp_i[XW-1]};

  always_comb begin
    efield = '0;
    frac   = '0;
    case (fp_class_e'(cls_i))
      CL_NORM: begin
        efield = exp_i[EXP_W-1:0] + EXP_W'(BIAS);
        frac   = sig_i[FRAC_W-1:0];
      end
      CL_SUB:  frac = sig_i[FRAC_W-1:0];
      CL_INF:  efield = '1;
      CL_QNAN, CL_SNAN: begin
        efield = '1;
        frac   = sig_i[FRAC_W-1:0];
      end
      default: ;
    endcase
    fp_o = {sign_i, efield, frac};
  end
endmodule

// File: rtl/fp_view_fmt.sv
module fp_view_fmt
  import fpk_pkg::*;
#(
  parameter int SIG_W  = 53,
  parameter int HALF_W = 32,
  localparam int WIDE  = 2 * HALF_W
) (
  input  fp_class_e            cls_i,
  input  logic [SIG_W-1:0]     sig_i,
  input  logic                 flag_mode,
  input  logic                 split_mode,
  output logic [2:0]           cls_o,
  output logic [N_CLASS-1:0]   flags_o,
  output logic [SIG_W-1:0]     sig_o,
  output logic [HALF_W-1:0]    hi_o,
  output logic [HALF_W-1:0]    lo_o
);
  logic [WIDE-1:0] sig_ext;

  assign sig_ext = WIDE'(sig_i);
  assign cls_o   = flag_mode ? 3'd0 : cls_i;
  assign sig_o   = split_mode ? '0 : sig_i;
  assign hi_o    = split_mode ? sig_ext[WIDE-1:HALF_W] : '0;
  assign lo_o    = split_mode ? sig_ext[HALF_W-1:0] : '0;

  for (genvar k = 0; k < N_CLASS; k++) begin : g_flag
    assign flags_o[k] = flag_mode && (cls_i == fp_class_e'(k));
  end
endmodule

// File: rtl/fp_pack_unit.sv
module fp_pack_unit
  import fpk_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int HALF_W = 32,
  localparam int W     = 1 + EXP_W + FRAC_W,
  localparam int XW    = EXP_W + 1,
  localparam int SIG_W = FRAC_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flag_mode,
  input  logic               split_mode,
  input  logic [W-1:0]       fp_in,
  input  logic               pk_sign,
  input  logic [XW-1:0]      pk_exp,
  input  logic [SIG_W-1:0]   pk_sig,
  input  logic [2:0]         pk_class,
  output logic               up_sign,
  output logic [XW-1:0]      up_exp,
  output logic [SIG_W-1:0]   up_sig,
  output logic [HALF_W-1:0]  up_sig_hi,
  output logic [HALF_W-1:0]  up_sig_lo,
  output logic [2:0]         up_class,
  output logic [N_CLASS-1:0] up_flags,
  output logic [W-1:0]       rp_out
);
  logic               u_sign;
  logic [XW-1:0]      u_exp;
  logic [SIG_W-1:0]   u_sig_raw, f_sig;
  fp_class_e          u_cls;
  logic [2:0]         f_cls;
  logic [N_CLASS-1:0] f_flags;
  logic [HALF_W-1:0]  f_hi, f_lo;
  logic [W-1:0]       r_word;

  fp_unpack_core #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack (
    .fp_i(fp_in), .sign_o(u_sign), .exp_o(u_exp), .sig_o(u_sig_raw), .cls_o(u_cls)
  );

  fp_view_fmt #(.SIG_W(SIG_W), .HALF_W(HALF_W)) u_fmt (
    .cls_i(u_cls), .sig_i(u_sig_raw), .flag_mode(flag_mode), .split_mode(split_mode),
    .cls_o(f_cls), .flags_o(f_flags), .sig_o(f_sig), .hi_o(f_hi), .lo_o(f_lo)
  );

  fp_repack_core #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_repack (
    .sign_i(pk_sign), .exp_i(pk_exp), .sig_i(pk_sig), .cls_i(pk_class), .fp_o(r_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      up_sign   <= 1'b0;
      up_exp    <= '0;
      up_sig    <= '0;
      up_sig_hi <= '0;
      up_sig_lo <= '0;
      up_class  <= '0;
      up_flags  <= '0;
      rp_out    <= '0;
    end else begin
      up_sign   <= u_sign;
      up_exp    <= u_exp;
      up_sig    <= f_sig;
      up_sig_hi <= f_hi;
      up_sig_lo <= f_lo;
      up_class  <= f_cls;
      up_flags  <= f_flags;
      rp_out    <= r_word;
    end
  end

  // R1: normal operands surface the hidden bit
  a_r1_hidden_bit: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(split_mode) && $past(fp_in[FRAC_W +: EXP_W]) != '0 &&
     $past(fp_in[FRAC_W +: EXP_W]) != '1) |-> up_sig[FRAC_W]);

  // R3: a zero operand reports the zero class
  a_r3_zero_class: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(flag_mode) && $past(fp_in[W-2:0]) == '0) |->
    (up_class == 3'd0 && up_exp == '0));

  // R5: code mode keeps flags quiet
  a_r5_no_flags: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(flag_mode)) |-> up_flags == '0);

  // R6: flag mode raises exactly one flag
  a_r6_one_flag: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(flag_mode)) |-> ($countones(up_flags) == 1 && up_class == 3'd0));

  // R7: split mode empties the single-word significand
  a_r7_split_word: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(split_mode)) |-> up_sig == '0);

  // R9: NaN repack keeps the payload under an all-ones exponent
  a_r9_nan_payload: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(pk_class) == 3'd4 || $past(pk_class) == 3'd5)) |->
    (rp_out[FRAC_W +: EXP_W] == '1 && rp_out[FRAC_W-1:0] == $past(pk_sig[FRAC_W-1:0])));

  // R10: zero repack ignores significand and exponent
  a_r10_zero_ignores: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(pk_class) == 3'd0) |->
    (rp_out[W-2:0] == '0 && rp_out[W-1] == $past(pk_sign)));
endmodule

// File: tb/fp_pack_unit_tb.sv
module fp_pack_unit_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        flag_mode, split_mode;
  logic [63:0] fp_in;
  logic        pk_sign;
  logic [11:0] pk_exp;
  logic [52:0] pk_sig;
  logic [2:0]  pk_class;
  logic        up_sign;
  logic [11:0] up_exp;
  logic [52:0] up_sig;
  logic [31:0] up_sig_hi, up_sig_lo;
  logic [2:0]  up_class;
  logic [5:0]  up_flags;
  logic [63:0] rp_out;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  fp_pack_unit u_dut (
    .clk(clk), .rst(rst), .flag_mode(flag_mode), .split_mode(split_mode),
    .fp_in(fp_in), .pk_sign(pk_sign), .pk_exp(pk_exp), .pk_sig(pk_sig),
    .pk_class(pk_class), .up_sign(up_sign), .up_exp(up_exp), .up_sig(up_sig),
    .up_sig_hi(up_sig_hi), .up_sig_lo(up_sig_lo), .up_class(up_class),
    .up_flags(up_flags), .rp_out(rp_out)
  );

  localparam int NV = 14;
  localparam logic [63:0] VEC [NV] = '{
    64'h3FF0000000000000, 64'hC004000000000000, 64'h7FEFFFFFFFFFFFFF,
    64'h0010000000000000, 64'h0000000000000001, 64'h800FFFFFFFFFFFFF,
    64'h0000000000000000, 64'h8000000000000000, 64'h7FF0000000000000,
    64'hFFF0000000000000, 64'h7FF8000000000001, 64'h7FF0000000000001,
    64'hFFF8DEADBEEF1234, 64'h7FF7FFFFFFFFFFFF
  };
  localparam logic [2:0] VCL [NV] = '{
    3'd2, 3'd2, 3'd2, 3'd2, 3'd1, 3'd1, 3'd0, 3'd0, 3'd3, 3'd3, 3'd4, 3'd5, 3'd4, 3'd5
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected exponent and significand derived from the requirement text
  function automatic void model(input logic [63:0] x, output logic [11:0] e,
                                output logic [52:0] s);
    logic [10:0] ef;
    ef = x[62:52];
    if (ef == 11'd0 && x[51:0] == 52'd0) begin e = 12'd0; s = 53'd0; end
    else if (ef == 11'd0) begin e = 12'd0 - 12'd1022; s = {1'b0, x[51:0]}; end
    else if (ef == 11'h7FF) begin e = 12'd1024; s = {1'b0, x[51:0]}; end
    else begin e = {1'b0, ef} - 12'd1023; s = {1'b1, x[51:0]}; end
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic repack(input logic s, input logic [11:0] e, input logic [52:0] g,
                        input logic [2:0] c);
    pk_sign = s; pk_exp = e; pk_sig = g; pk_class = c;
    step();
  endtask

  initial begin
    #(20 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [11:0] ee;
    logic [52:0] es;
    rst = 1'b1; flag_mode = 1'b0; split_mode = 1'b0;
    fp_in = 64'h3FF0000000000000;
    pk_sign = 1'b1; pk_exp = 12'd5; pk_sig = 53'h1FFFFFFFFFFFFF; pk_class = 3'd2;
    step(); step();
    // R11: reset clears every output
    chk("R11 reset rp_out", rp_out, 64'd0);
    chk("R11 reset up_sig", {11'd0, up_sig}, 64'd0);
    chk("R11 reset up_class", {61'd0, up_class}, 64'd0);
    chk("R11 reset up_exp", {52'd0, up_exp}, 64'd0);
    rst = 1'b0;
    pk_class = 3'd0;
    step();

    // R1 R2 R3 R4 R5 R12: table walk with round trip
    for (int i = 0; i < NV; i++) begin
      flag_mode = 1'b0; split_mode = 1'b0;
      fp_in = VEC[i];
      step();
      model(VEC[i], ee, es);
      chk($sformatf("R1-class vec%0d (R2 R3 R4 R5)", i), {61'd0, up_class}, {61'd0, VCL[i]});
      chk($sformatf("R1 exp vec%0d", i), {52'd0, up_exp}, {52'd0, ee});
      chk($sformatf("R1 sig vec%0d", i), {11'd0, up_sig}, {11'd0, es});
      chk($sformatf("R1 sign vec%0d", i), {63'd0, up_sign}, {63'd0, VEC[i][63]});
      chk($sformatf("R5 flags zero vec%0d", i), {58'd0, up_flags}, 64'd0);
      chk($sformatf("R7 halves zero vec%0d", i), {up_sig_hi, up_sig_lo}, 64'd0);
      pk_sign = up_sign; pk_exp = up_exp; pk_sig = up_sig; pk_class = up_class;
      step();
      chk($sformatf("R12 round trip vec%0d", i), rp_out, VEC[i]);
    end

    // R6: one-hot flags per class
    for (int i = 0; i < NV; i++) begin
      flag_mode = 1'b1; fp_in = VEC[i];
      step();
      chk($sformatf("R6 flags vec%0d", i), {58'd0, up_flags}, 64'd1 << VCL[i]);
      chk($sformatf("R6 class cleared vec%0d", i), {61'd0, up_class}, 64'd0);
    end
    flag_mode = 1'b0;

    // R7: split significand halves
    split_mode = 1'b1;
    for (int i = 0; i < 6; i++) begin
      fp_in = VEC[i];
      step();
      model(VEC[i], ee, es);
      chk($sformatf("R7 hi vec%0d", i), {32'd0, up_sig_hi}, {43'd0, es[52:32]});
      chk($sformatf("R7 lo vec%0d", i), {32'd0, up_sig_lo}, {32'd0, es[31:0]});
      chk($sformatf("R7 word zero vec%0d", i), {11'd0, up_sig}, 64'd0);
    end
    split_mode = 1'b0;

    // R8: normal and subnormal repack
    repack(1'b0, 12'hFFB, 53'h1ABCDEF0123456, 3'd2);
    chk("R8 normal exp -5", rp_out, {1'b0, 11'd1018, 52'hABCDEF0123456});
    repack(1'b1, 12'd1023, 53'h1000000000000F, 3'd2);
    chk("R8 normal exp max", rp_out, {1'b1, 11'd2046, 52'h000000000000F});
    repack(1'b1, 12'd77, 53'h00000012345678, 3'd1);
    chk("R8 subnormal", rp_out, {1'b1, 11'd0, 52'h0000012345678});

    // R9: NaN payload kept
    repack(1'b0, 12'd3, 53'h00000000000ABC, 3'd5);
    chk("R9 snan payload", rp_out, {1'b0, 11'h7FF, 52'h0000000000ABC});
    repack(1'b1, 12'd0, 53'h1C000000000001, 3'd4);
    chk("R9 qnan payload", rp_out, {1'b1, 11'h7FF, 52'hC000000000001});

    // R10: significand and exponent ignored for zero, infinity and unused codes
    repack(1'b1, 12'd300, 53'h1FFFFFFFFFFFFF, 3'd0);
    chk("R10 zero ignores sig", rp_out, 64'h8000000000000000);
    repack(1'b0, 12'd12, 53'h1FFFFFFFFFFFFF, 3'd3);
    chk("R10 inf ignores sig", rp_out, 64'h7FF0000000000000);
    repack(1'b1, 12'd9, 53'h0123456789ABCD, 3'd6);
    chk("R10 code6 zero", rp_out, 64'h8000000000000000);
    repack(1'b0, 12'd9, 53'h0123456789ABCD, 3'd7);
    chk("R10 code7 zero", rp_out, 64'h0000000000000000);

    // R11: one cycle of latency, then reset mid-run
    fp_in = 64'h4000000000000000;
    @(posedge clk); #1;
    fp_in = 64'h3FF0000000000000;
    step();
    chk("R11 latency exp", {52'd0, up_exp}, 64'd1);
    rst = 1'b1;
    step();
    chk("R11 mid reset sig", {11'd0, up_sig}, 64'd0);
    chk("R11 mid reset sign", {63'd0, up_sign}, 64'd0);
    rst = 1'b0;
    step();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule